// File: doc/BRIEF.md
# NCO Nanosecond Time-of-Day Counter

This block keeps a free-running nanosecond time count for precision timestamping. On every edge of its reference clock, a numerically controlled oscillator adds a fixed-point step to a 72-bit accumulator. The step has 28 fractional bits, and the 44 integer bits above them form the nanosecond count. The reset step is 8.0 ns per cycle, which suits a 125 MHz reference. Software trims frequency by moving the step above or below that nominal value. Each unit of the step moves the rate by 2^-28 ns per cycle, so a trim of p parts per billion is a step offset of |p|·2^28/125e6, rounded to the nearest integer.

Software sees four 32-bit words on a small synchronous bus. Word selector 0 (FINE) holds count bits [3:0] in data bits [3:0]. Selector 1 (MID) holds count bits [35:4]. Selector 2 (TOP) holds count bits [43:36]. Selector 3 (STEP) holds the increment.

The TOP word uses different byte lanes for reading and writing. It reads back in data bits [7:0], and it is written from data bits [15:8]. A TOP read does not return the live top bits. It returns a holding register that captures the live top bits whenever MID is read, so that a MID read followed by a TOP read gives one coherent time. A step of zero freezes the count. Writing zero to all four words leaves the block cleared and halted.

Top module: `nco_time_counter`

## Requirements
- R1: Reset behaviour:
  - While rst_n is low, rd_data reads 0.
  - After reset the count is 0.
  - After reset the STEP word reads 0x80000000.
- R2: On every clock edge without a time-field write, the accumulator adds the STEP value. With step 0x80000000 the count rises by 8 ns per cycle. A STEP write takes effect from the next edge.
- R3: While STEP is 0, the count does not change.
- R4: Fractional step bits accumulate across cycles and carry into the nanosecond count. For example, a step of 0x18000000 gives 1.5 ns per cycle.
- R5: Writing MID (selector 1) loads count bits [35:4] from all 32 data bits. Reading MID returns those bits.
- R6: TOP (selector 2) lanes:
  - A write loads count bits [43:36] from data bits [15:8], ignoring all other data bits.
  - A read returns the held top value in data bits [7:0], with bits [31:8] at zero.
  - A TOP write also loads the holding register.
- R7: Writing FINE (selector 0) loads count bits [3:0] from data bits [3:0] and clears the 28 fractional bits. Reading FINE returns count bits [3:0] in data bits [3:0], with the rest at zero.
- R8: A time-field write changes only that field's bits, and the count does not advance on that edge.
- R9: The count wraps silently from 2^44-1 to low values, and the carry is discarded.
- R10: A MID read captures the live count bits [43:36] on the same edge. Later TOP reads return that captured value until the next MID read or TOP write.
- R11: Read data appears one cycle after bus_rd and is held unchanged on cycles without bus_rd.
- R12: After 0 is written to all four words, every word reads 0 and the count stays 0.
- R13: STEP (selector 3) reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one accumulation per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word selector: 0 FINE, 1 MID, 2 TOP, 3 STEP |
| bus_wr | input | 1 | Write strobe for the selected word |
| bus_rd | input | 1 | Read strobe; data valid one cycle later |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
Two functions can fall on the same edge: a MID read, and the carry of the running count out of bit 35 into the top field. To provoke this, the bench parks the count 8 ns short of that carry with an 8 ns step. It then issues MID and TOP reads on consecutive cycles across the rollover. The result is judged coherent when the TOP read returns the top value that belonged with the preceding MID read, not the live one. The same alternating reads one cycle further on must then show the new MID and TOP values.

// File: rtl/nco_time_pkg.sv
// Package: shared widths, reset step and word selectors for the NCO time counter.
// Assumes the integer count splits exactly into FINE, MID and TOP fields.
package nco_time_pkg;
    parameter int unsigned NS_W       = 44;
    parameter int unsigned FRAC_W     = 28;
    parameter int unsigned FINE_W     = 4;
    parameter int unsigned MID_W      = 32;
    parameter int unsigned TOP_W      = 8;
    parameter int unsigned BUS_W      = 32;
    parameter int unsigned SEL_W      = 2;
    parameter int unsigned TOP_WR_LSB = 8;
    parameter logic [BUS_W-1:0] STEP_RESET = 32'h8000_0000;

    typedef enum logic [SEL_W-1:0] {
        SEL_FINE = 2'd0,
        SEL_MID  = 2'd1,
        SEL_TOP  = 2'd2,
        SEL_STEP = 2'd3
    } word_sel_e;
endpackage

// File: rtl/nco_step_reg.sv
// Module: holds the fixed-point step added to the accumulator each cycle.
// Assumes a synchronous active-low reset; a load takes effect from the next edge.
module nco_step_reg #(
    parameter int unsigned        STEP_W    = 32,
    parameter logic [STEP_W-1:0]  RST_VALUE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STEP_W-1:0] load_val,
    output logic [STEP_W-1:0] step_q
);
    // Purpose: capture software step writes, default to the nominal rate.
    always_ff @(posedge clk) begin
        if (!rst_n)    step_q <= RST_VALUE;
        else if (load) step_q <= load_val;
    end
endmodule

// File: rtl/nco_accum.sv
// Module: integer-plus-fraction time accumulator with per-field loads.
// Assumes at most one field load per cycle; a load edge does not advance the count,
// and the carry out of the top integer bit is dropped.
module nco_accum #(
    parameter int unsigned NS_W   = 44,
    parameter int unsigned FRAC_W = 28,
    parameter int unsigned FINE_W = 4,
    parameter int unsigned MID_W  = 32,
    parameter int unsigned TOP_W  = 8,
    parameter int unsigned STEP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_fine,
    input  logic              ld_mid,
    input  logic              ld_top,
    input  logic [FINE_W-1:0] fine_val,
    input  logic [MID_W-1:0]  mid_val,
    input  logic [TOP_W-1:0]  top_val,
    input  logic [STEP_W-1:0] step,
    output logic [NS_W+FRAC_W-1:0] acc_q,
    output logic [FINE_W-1:0] fine_o,
    output logic [MID_W-1:0]  mid_o,
    output logic [TOP_W-1:0]  top_o
);
    localparam int unsigned ACC_W    = NS_W + FRAC_W;
    localparam int unsigned FINE_LSB = FRAC_W;
    localparam int unsigned MID_LSB  = FRAC_W + FINE_W;
    localparam int unsigned TOP_LSB  = FRAC_W + FINE_W + MID_W;
    localparam int unsigned PAD_W    = ACC_W - STEP_W;

    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] acc_d;

    // Purpose: modulo-2^ACC_W sum of the count and the zero-extended step.
    always_comb sum = acc_q + {{PAD_W{1'b0}}, step};

    // Purpose: pick a field load or the accumulated value for the next edge.
    always_comb begin
        acc_d = acc_q;
        if (ld_fine) begin
            acc_d[FRAC_W-1:0]         = '0;
            acc_d[FINE_LSB +: FINE_W] = fine_val;
        end else if (ld_mid) begin
            acc_d[MID_LSB +: MID_W]   = mid_val;
        end else if (ld_top) begin
            acc_d[TOP_LSB +: TOP_W]   = top_val;
        end else begin
            acc_d = sum;
        end
    end

    // Purpose: the accumulator register itself.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // Purpose: slice the live integer count into its software fields.
    always_comb begin
        fine_o = acc_q[FINE_LSB +: FINE_W];
        mid_o  = acc_q[MID_LSB +: MID_W];
        top_o  = acc_q[TOP_LSB +: TOP_W];
    end
endmodule

// File: rtl/nco_read_port.sv
// Module: registered read mux with a top-field holding register.
// Assumes one read per cycle; a MID read snapshots the live top bits, a TOP
// write reloads the holding register, and rd_data holds between reads.
module nco_read_port
    import nco_time_pkg::*;
#(
    parameter int unsigned FINE_W = 4,
    parameter int unsigned MID_W  = 32,
    parameter int unsigned TOP_W  = 8,
    parameter int unsigned BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              top_load,
    input  logic [TOP_W-1:0]  top_load_val,
    input  logic [FINE_W-1:0] fine_live,
    input  logic [MID_W-1:0]  mid_live,
    input  logic [TOP_W-1:0]  top_live,
    input  logic [BUS_W-1:0]  step_live,
    output logic [TOP_W-1:0]  hold_q,
    output logic [BUS_W-1:0]  rd_data
);
    logic [BUS_W-1:0] mux;

    // Purpose: choose the word presented for the current read.
    always_comb begin
        mux = '0;
        case (rd_sel)
            SEL_FINE: mux[FINE_W-1:0] = fine_live;
            SEL_MID:  mux[MID_W-1:0]  = mid_live;
            SEL_TOP:  mux[TOP_W-1:0]  = hold_q;
            default:  mux             = step_live;
        endcase
    end

    // Purpose: keep the top field coherent with the last MID read or TOP write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hold_q <= '0;
        else if (top_load)                    hold_q <= top_load_val;
        else if (rd_en && rd_sel == SEL_MID)  hold_q <= top_live;
    end

    // Purpose: one-cycle registered read data, held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mux;
    end
endmodule

// File: rtl/nco_time_counter.sv
// Module: top of the NCO nanosecond counter; decodes the four-word bus and
// connects the step register, accumulator and read port.
// Assumes bus_addr is valid whenever bus_wr or bus_rd is high.
module nco_time_counter
    import nco_time_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] rd_data
);
    localparam int unsigned ACC_W = NS_W + FRAC_W;

    logic              wr_fine, wr_mid, wr_top, wr_step;
    logic [BUS_W-1:0]  step_q;
    logic [ACC_W-1:0]  acc_q;
    logic [FINE_W-1:0] fine_live;
    logic [MID_W-1:0]  mid_live;
    logic [TOP_W-1:0]  top_live;
    logic [TOP_W-1:0]  hold_q;
    logic [TOP_W-1:0]  top_wr_val;

    // Purpose: one write strobe per addressed word, top byte taken from its write lane.
    always_comb begin
        wr_fine    = bus_wr && (bus_addr == SEL_FINE);
        wr_mid     = bus_wr && (bus_addr == SEL_MID);
        wr_top     = bus_wr && (bus_addr == SEL_TOP);
        wr_step    = bus_wr && (bus_addr == SEL_STEP);
        top_wr_val = bus_wdata[TOP_WR_LSB +: TOP_W];
    end

    nco_step_reg #(.STEP_W(BUS_W), .RST_VALUE(STEP_RESET)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_step),
        .load_val (bus_wdata),
        .step_q   (step_q)
    );

    nco_accum #(
        .NS_W(NS_W), .FRAC_W(FRAC_W), .FINE_W(FINE_W),
        .MID_W(MID_W), .TOP_W(TOP_W), .STEP_W(BUS_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_fine  (wr_fine),
        .ld_mid   (wr_mid),
        .ld_top   (wr_top),
        .fine_val (bus_wdata[FINE_W-1:0]),
        .mid_val  (bus_wdata[MID_W-1:0]),
        .top_val  (top_wr_val),
        .step     (step_q),
        .acc_q    (acc_q),
        .fine_o   (fine_live),
        .mid_o    (mid_live),
        .top_o    (top_live)
    );

    nco_read_port #(
        .FINE_W(FINE_W), .MID_W(MID_W), .TOP_W(TOP_W), .BUS_W(BUS_W)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (bus_rd),
        .rd_sel       (bus_addr),
        .top_load     (wr_top),
        .top_load_val (top_wr_val),
        .fine_live    (fine_live),
        .mid_live     (mid_live),
        .top_live     (top_live),
        .step_live    (step_q),
        .hold_q       (hold_q),
        .rd_data      (rd_data)
    );
endmodule

// File: rtl/nco_time_checker.sv
// Module: property checker for nco_time_counter, attached by bind below.
// Assumes it observes the top's bus pins plus its step, accumulator and hold state.
module nco_time_checker
    import nco_time_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [SEL_W-1:0]        bus_addr,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [BUS_W-1:0]        bus_wdata,
    input logic [BUS_W-1:0]        rd_data,
    input logic [BUS_W-1:0]        step_q,
    input logic [NS_W+FRAC_W-1:0]  acc_q,
    input logic [TOP_W-1:0]        hold_q
);
    localparam int unsigned ACC_W   = NS_W + FRAC_W;
    localparam int unsigned TOP_LSB = FRAC_W + FINE_W + MID_W;
    localparam int unsigned MID_LSB = FRAC_W + FINE_W;

    logic             time_wr;
    logic [ACC_W-1:0] acc_plus;

    // Purpose: flag edges on which a time field is being loaded.
    always_comb time_wr = bus_wr && (bus_addr != SEL_STEP);
    // Purpose: the value the count should reach on a free-running edge.
    always_comb acc_plus = acc_q + {{(ACC_W-BUS_W){1'b0}}, step_q};

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && step_q == STEP_RESET && rd_data == '0));

    a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        !time_wr |=> acc_q == $past(acc_plus));

    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == '0 && !time_wr) |=> $stable(acc_q));

    a_r6_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_TOP) |=>
            acc_q[TOP_LSB +: TOP_W] == $past(bus_wdata[TOP_WR_LSB +: TOP_W]));

    a_r7_fine_clears_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_FINE) |=>
            (acc_q[FRAC_W-1:0] == '0 &&
             acc_q[FRAC_W +: FINE_W] == $past(bus_wdata[FINE_W-1:0])));

    a_r8_mid_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_MID) |=>
            ($stable(acc_q[MID_LSB-1:0]) && $stable(acc_q[TOP_LSB +: TOP_W])));

    a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SEL_MID && !bus_wr) |=>
            hold_q == $past(acc_q[TOP_LSB +: TOP_W]));

    a_r11_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rd_data));
endmodule

bind nco_time_counter nco_time_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .step_q    (step_q),
    .acc_q     (acc_q),
    .hold_q    (hold_q)
);

// File: tb/nco_time_counter_bench.sv
// Bench: vector table for field access, then directed timing and corner tests.
module nco_time_counter_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [1:0] A_FINE = 2'd0, A_MID = 2'd1, A_TOP = 2'd2, A_STEP = 2'd3;

    // {is_write, addr, wdata, expected, requirement number}
    localparam int NV = 14;
    localparam logic [74:0] VEC [NV] = '{
        {1'b1, 2'd3, 32'h0000_0000, 32'h0, 8'd3},          // R3 halt
        {1'b1, 2'd1, 32'h1234_5678, 32'h0, 8'd5},          // R5
        {1'b1, 2'd2, 32'h0000_AB00, 32'h0, 8'd6},          // R6
        {1'b1, 2'd0, 32'hFFFF_FFF9, 32'h0, 8'd7},          // R7
        {1'b0, 2'd0, 32'h0, 32'h0000_0009, 8'd7},          // R7 fine readback
        {1'b0, 2'd1, 32'h0, 32'h1234_5678, 8'd5},          // R5 mid readback
        {1'b0, 2'd2, 32'h0, 32'h0000_00AB, 8'd6},          // R6 / R10
        {1'b1, 2'd2, 32'h1234_5600, 32'h0, 8'd6},          // R6 only [15:8]
        {1'b0, 2'd2, 32'h0, 32'h0000_0056, 8'd6},          // R6
        {1'b0, 2'd1, 32'h0, 32'h1234_5678, 8'd8},          // R8 mid untouched
        {1'b0, 2'd0, 32'h0, 32'h0000_0009, 8'd8},          // R8 fine untouched
        {1'b0, 2'd3, 32'h0, 32'h0000_0000, 8'd13},         // R13
        {1'b1, 2'd3, 32'h00AB_CDEF, 32'h0, 8'd13},         // R13
        {1'b0, 2'd3, 32'h0, 32'h00AB_CDEF, 8'd13}          // R13
    };

    nco_time_counter u_nco_time_counter (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        rd_check(A_STEP, 32'h8000_0000, "R1 step after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][74]) wr(VEC[i][73:72], VEC[i][71:40]);
            else begin
                rd(VEC[i][73:72], v);
                check($sformatf("R%0d vector %0d", VEC[i][7:0], i), v, VEC[i][39:8]);
            end
        end

        // R2: 10 edges at 8 ns -> 80 ns = 0x50
        wr(A_STEP, 32'h0); wr(A_FINE, 32'h0); wr(A_MID, 32'h0); wr(A_TOP, 32'h0);
        wr(A_STEP, 32'h8000_0000); idle(9); wr(A_STEP, 32'h0);
        rd_check(A_FINE, 32'h0, "R2 fine after 10 steps");
        rd_check(A_MID, 32'h5, "R2 mid after 10 steps");

        // R3: frozen with zero step
        idle(5);
        rd_check(A_MID, 32'h5, "R3 mid frozen");
        rd_check(A_FINE, 32'h0, "R3 fine frozen");

        // R4: 3 x 1.5 ns -> 4.5
        wr(A_STEP, 32'h1800_0000); idle(2); wr(A_STEP, 32'h0);
        rd_check(A_FINE, 32'h4, "R4 fine after 4.5 ns");
        // R7: fine write drops the .5 -> 4.0 + 4.5 = 8.5
        wr(A_FINE, 32'h4);
        wr(A_STEP, 32'h1800_0000); idle(2); wr(A_STEP, 32'h0);
        rd_check(A_FINE, 32'h8, "R7 fraction cleared by fine write");
        // R4: 8.5 + 4.5 = 13.0
        wr(A_STEP, 32'h1800_0000); idle(2); wr(A_STEP, 32'h0);
        rd_check(A_FINE, 32'hD, "R4 fraction carried");
        rd_check(A_MID, 32'h5, "R4 mid unchanged");

        // R8: mid write edge does not advance
        wr(A_FINE, 32'h0); wr(A_MID, 32'h0); wr(A_TOP, 32'h0);
        wr(A_STEP, 32'h8000_0000); wr(A_MID, 32'h100); wr(A_STEP, 32'h0);
        rd_check(A_FINE, 32'h8, "R8 fine after mid write");
        rd_check(A_MID, 32'h100, "R8 mid after write");

        // R9: 2^44-1 + 8 wraps to 7
        wr(A_TOP, 32'h0000_FF00); wr(A_MID, 32'hFFFF_FFFF); wr(A_FINE, 32'hF);
        wr(A_STEP, 32'h8000_0000); wr(A_STEP, 32'h0);
        rd_check(A_FINE, 32'h7, "R9 fine after wrap");
        rd_check(A_MID, 32'h0, "R9 mid after wrap");
        rd_check(A_TOP, 32'h0, "R9 top after wrap");

        // R10: MID read coincident with carry into top field
        wr(A_FINE, 32'h0); wr(A_MID, 32'hFFFF_FFFF); wr(A_TOP, 32'h0000_0100);
        wr(A_STEP, 32'h8000_0000); idle(1);
        rd_check(A_MID, 32'hFFFF_FFFF, "R10 mid before carry");
        rd_check(A_TOP, 32'h1, "R10 top held with mid");
        rd_check(A_MID, 32'h0, "R10 mid after carry");
        rd_check(A_TOP, 32'h2, "R10 top after carry");
        wr(A_STEP, 32'h0);

        // R11: read data holds across idle and writes
        rd(A_STEP, v);
        check("R11 step read", v, 32'h0);
        wr(A_FINE, 32'h3); idle(3);
        check("R11 rd_data held", rd_data, 32'h0);
        rd(A_FINE, v);
        idle(4);
        check("R11 rd_data held after fine read", rd_data, 32'h3);

        // R12: all words zero -> cleared and halted
        wr(A_FINE, 32'h0); wr(A_MID, 32'h0); wr(A_TOP, 32'h0); wr(A_STEP, 32'h0);
        idle(5);
        rd_check(A_FINE, 32'h0, "R12 fine");
        rd_check(A_MID, 32'h0, "R12 mid");
        rd_check(A_TOP, 32'h0, "R12 top");
        rd_check(A_STEP, 32'h0, "R12 step");

        finish_run();
    end
endmodule